// File: doc/BRIEF.md
# Bit-Set Calibration Store Command Decoder

This block is the target-side logic of a calibration store that an external test station drives with a stream of commands. Each command carries a 4-bit code, a 7-bit address and a 16-bit data field, and it is qualified by a valid strobe. The block holds a 128-bit non-volatile array, modelled in flip-flops and seen as eight 16-bit words. Word 0 is the configuration word and words 1 to 7 back seven volatile coefficient registers.

The array has two write operations. A program command sets a single addressed bit to 1. A block erase clears every bit to 0. There is no way to clear one bit on its own. Neither operation takes effect at once: the same command has to arrive a parameterised number of times in a row (375 by default) before it commits.

Start-conversion codes do two things. They issue a one-cycle conversion pulse. From their low bits they also decide whether the coefficient registers reload from the array and whether the serial data outputs are enabled. A direct coefficient write changes only a volatile register.

Top module: `calStore`

## Requirements
- R1: While reset is asserted and in the first cycle after it, all seven coefficient registers read 0, `outEnable` is 0, `busy` is 0 and `convStart` is 0.
- R2: Code 1h with address bits [2:0] = k, where k is 1 to 7, loads `cmdData` into coefficient register k (bits [(k-1)*16 +: 16] of `coefFlat`) at the next edge. Index 0 changes nothing, and code 1h never alters the array.
- R3: Code 2h sets array bit `cmdAddr` to 1 on the REPEAT-th consecutive identical command, with 375 as the default. No other bit changes, and a bit never goes from 1 to 0 except through a block erase.
- R4: A program sequence that is interrupted before REPEAT identical commands commits nothing. This holds whether the interruption is a different valid code or a different address. The next matching command starts the count again from one.
- R5: Code 4h repeated REPEAT times in a row clears all 128 array bits to 0. The address field plays no part in the erase count.
- R6: `busy` is 1 from the first program or erase command of a run until that run commits or is broken, and 0 otherwise.
- R7: Codes 8h, Ah, Ch and Eh produce a one-cycle `convStart` pulse after the edge that accepts them. Code bit 2 = 0 sets `outEnable` to 1, and code bit 2 = 1 sets it to 0.
- R8: When code bit 1 of a start-conversion code is 1, each coefficient register k is loaded from array word k (bits [16k+15:16k]). When that bit is 0, the registers keep their values.
- R9: The reserved codes 3h, 5h, 6h, 7h, 9h, Bh, Dh and Fh change no output and no stored state, and they do not break a repeat run that is in progress.
- R10: Reset leaves the array contents unchanged.
- R11: Cycles with `cmdValid` low neither advance nor break a repeat run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Qualifies the command fields for one cycle |
| cmdCode | input | 4 | Command code |
| cmdAddr | input | 7 | Array bit address, or coefficient index in bits [2:0] |
| cmdData | input | 16 | Coefficient value for code 1h |
| nvmBits | output | 128 | Current array contents |
| coefFlat | output | 112 | Coefficient registers 1..7 packed, register 1 in the low bits |
| outEnable | output | 1 | Serial data output enable |
| convStart | output | 1 | One-cycle conversion start pulse |
| busy | output | 1 | Program or erase run in progress, not yet committed |

## Verification
The hardest states to reach are the ones one command short of a commit. One of these is a run of 374 identical program commands that is then broken. The other is a run that is interleaved with idle cycles and reserved codes and must still commit on its 375th real command. The bench reaches both by issuing long bursts from a loop. It checks `busy` and the array at the step just before the commit and again just after it. It then reloads the coefficient registers from the array, so the programmed bits also show up in the coefficient registers.

// File: rtl/calPkg.sv
package calPkg;
  // Strobes from the command controller to the storage datapath
  typedef struct packed {
    logic setBit;    // commit a single-bit program
    logic eraseAll;  // commit a full-array clear
    logic coefWr;    // volatile coefficient write
    logic reload;    // copy array words into coefficient registers
    logic convGo;    // start-conversion accepted
    logic oeVal;     // output-enable value for convGo
  } ctlStrobes;

  localparam logic [3:0] CODE_NOP   = 4'h0;
  localparam logic [3:0] CODE_COEF  = 4'h1;
  localparam logic [3:0] CODE_PROG  = 4'h2;
  localparam logic [3:0] CODE_ERASE = 4'h4;
endpackage

// File: rtl/calCtl.sv
module calCtl #(
  parameter int ADDR_W = 7,
  parameter int REPEAT = 375,
  localparam int CNT_W = $clog2(REPEAT + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cmdValid,
  input  logic [3:0]           cmdCode,
  input  logic [ADDR_W-1:0]    cmdAddr,
  output calPkg::ctlStrobes    strb,
  output logic                 busy
);
  import calPkg::*;

  logic [CNT_W-1:0]  runCnt, nextCnt;
  logic [3:0]        runCode;
  logic [ADDR_W-1:0] runAddr;
  logic              runDone;
  logic isProg, isErase, isCoef, isNop, isConv, isKnown, active, sameRun, commit;

  always_comb begin
    isProg  = (cmdCode == CODE_PROG);
    isErase = (cmdCode == CODE_ERASE);
    isCoef  = (cmdCode == CODE_COEF);
    isNop   = (cmdCode == CODE_NOP);
    isConv  = cmdCode[3] & ~cmdCode[0];
    isKnown = isProg | isErase | isCoef | isNop | isConv;
    active  = cmdValid & isKnown;
    // An erase run ignores the address; a program run needs the same bit
    sameRun = (runCnt != '0) && (runCode == cmdCode) &&
              (isErase || (runAddr == cmdAddr));
    if (!sameRun)                        nextCnt = CNT_W'(1);
    else if (runCnt == CNT_W'(REPEAT))   nextCnt = runCnt;
    else                                 nextCnt = runCnt + CNT_W'(1);
    commit = (isProg | isErase) && !(sameRun && runDone) &&
             (nextCnt == CNT_W'(REPEAT));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runCnt  <= '0;
      runCode <= '0;
      runAddr <= '0;
      runDone <= 1'b0;
    end else if (active) begin
      if (isProg | isErase) begin
        runCnt  <= nextCnt;
        runCode <= cmdCode;
        runAddr <= cmdAddr;
        runDone <= (runDone & sameRun) | commit;
      end else begin
        runCnt  <= '0;
        runDone <= 1'b0;
      end
    end
  end

  assign busy = (runCnt != '0) && !runDone;

  always_comb begin
    strb.setBit   = active & isProg & commit;
    strb.eraseAll = active & isErase & commit;
    strb.coefWr   = active & isCoef;
    strb.reload   = active & isConv & cmdCode[1];
    strb.convGo   = active & isConv;
    strb.oeVal    = ~cmdCode[2];
  end
endmodule

// File: rtl/calData.sv
module calData #(
  parameter int WORDS  = 8,
  parameter int WORD_W = 16,
  localparam int BITS   = WORDS * WORD_W,
  localparam int ADDR_W = $clog2(BITS),
  localparam int IDX_W  = $clog2(WORDS),
  localparam int COEFS  = WORDS - 1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  calPkg::ctlStrobes         strb,
  input  logic [ADDR_W-1:0]         cmdAddr,
  input  logic [WORD_W-1:0]         cmdData,
  output logic [BITS-1:0]           nvmBits,
  output logic [COEFS*WORD_W-1:0]   coefFlat,
  output logic                      outEnable,
  output logic                      convStart
);
  logic [BITS-1:0] nvmArr;

  // Non-volatile model: deliberately outside the reset domain
  always_ff @(posedge clk) begin
    if (strb.eraseAll)    nvmArr <= '0;
    else if (strb.setBit) nvmArr[cmdAddr] <= 1'b1;
  end
  assign nvmBits = nvmArr;

  for (genvar k = 1; k <= COEFS; k++) begin : g_coef
    logic [WORD_W-1:0] coefReg;
    always_ff @(posedge clk) begin
      if (!rstN)
        coefReg <= '0;
      else if (strb.reload)
        coefReg <= nvmArr[k*WORD_W +: WORD_W];
      else if (strb.coefWr && (cmdAddr[IDX_W-1:0] == IDX_W'(k)))
        coefReg <= cmdData;
    end
    assign coefFlat[(k-1)*WORD_W +: WORD_W] = coefReg;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outEnable <= 1'b0;
      convStart <= 1'b0;
    end else begin
      convStart <= strb.convGo;
      if (strb.convGo) outEnable <= strb.oeVal;
    end
  end
endmodule

// File: rtl/calStore.sv
module calStore #(
  parameter int WORDS  = 8,
  parameter int WORD_W = 16,
  parameter int REPEAT = 375,
  localparam int BITS   = WORDS * WORD_W,
  localparam int ADDR_W = $clog2(BITS),
  localparam int COEFS  = WORDS - 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    cmdValid,
  input  logic [3:0]              cmdCode,
  input  logic [ADDR_W-1:0]       cmdAddr,
  input  logic [WORD_W-1:0]       cmdData,
  output logic [BITS-1:0]         nvmBits,
  output logic [COEFS*WORD_W-1:0] coefFlat,
  output logic                    outEnable,
  output logic                    convStart,
  output logic                    busy
);
  calPkg::ctlStrobes strb;

  calCtl #(.ADDR_W(ADDR_W), .REPEAT(REPEAT)) u_ctl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdCode(cmdCode),
    .cmdAddr(cmdAddr), .strb(strb), .busy(busy)
  );

  calData #(.WORDS(WORDS), .WORD_W(WORD_W)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .cmdAddr(cmdAddr), .cmdData(cmdData),
    .nvmBits(nvmBits), .coefFlat(coefFlat), .outEnable(outEnable),
    .convStart(convStart)
  );
endmodule

// File: rtl/calStoreChk.sv
module calStoreChk #(
  parameter int BITS   = 128,
  parameter int ADDR_W = 7,
  parameter int CW     = 112
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdValid,
  input logic [3:0]        cmdCode,
  input logic [ADDR_W-1:0] cmdAddr,
  input logic [BITS-1:0]   nvmBits,
  input logic [CW-1:0]     coefFlat,
  input logic              outEnable,
  input logic              convStart,
  input logic              busy
);
  logic isRes;
  assign isRes = (cmdCode[0] && cmdCode != 4'h1) || cmdCode == 4'h6;

  // R3
  bit_only_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((nvmBits & $past(nvmBits)) != $past(nvmBits)) |-> (nvmBits == '0));

  // R7
  conv_pulse_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    convStart |-> $past(cmdValid && cmdCode[3] && !cmdCode[0]));

  // R6
  busy_rise_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(cmdValid && (cmdCode == 4'h2 || cmdCode == 4'h4)));

  // R9
  reserved_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(cmdValid && isRes) |->
      ($stable(nvmBits) && $stable(coefFlat) && $stable(outEnable) && $stable(busy)));

  // R2
  coef_keeps_array_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(cmdValid && cmdCode == 4'h1) |-> $stable(nvmBits));

  // R11
  idle_keeps_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(!cmdValid) |-> ($stable(busy) && $stable(nvmBits) && $stable(coefFlat)));
endmodule

bind calStore calStoreChk #(.BITS(BITS), .ADDR_W(ADDR_W), .CW(COEFS*WORD_W)) u_chk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdCode(cmdCode), .cmdAddr(cmdAddr),
  .nvmBits(nvmBits), .coefFlat(coefFlat), .outEnable(outEnable),
  .convStart(convStart), .busy(busy)
);

// File: tb/sim_calStore.sv
module sim_calStore;
  localparam int CLK_PERIOD = 10;
  localparam int REP = 375;

  logic clk = 1'b0;
  logic rstN, cmdValid;
  logic [3:0] cmdCode;
  logic [6:0] cmdAddr;
  logic [15:0] cmdData;
  logic [127:0] nvmBits;
  logic [111:0] coefFlat;
  logic outEnable, convStart, busy;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  calStore u0 (.clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdCode(cmdCode),
    .cmdAddr(cmdAddr), .cmdData(cmdData), .nvmBits(nvmBits), .coefFlat(coefFlat),
    .outEnable(outEnable), .convStart(convStart), .busy(busy));

  typedef struct packed {
    logic [3:0]  code;
    logic [6:0]  addr;
    logic [15:0] data;
    logic [2:0]  idx;
    logic [15:0] expV;
    logic        expOe;
  } vec_t;

  localparam vec_t TBL [9] = '{
    '{4'h1, 7'd1, 16'h1111, 3'd1, 16'h1111, 1'b0},  // R2 reg1 write
    '{4'h1, 7'd7, 16'h7777, 3'd7, 16'h7777, 1'b0},  // R2 reg7 write
    '{4'h1, 7'd0, 16'hDEAD, 3'd1, 16'h1111, 1'b0},  // R2 index 0 ignored
    '{4'h8, 7'd0, 16'h0000, 3'd7, 16'h7777, 1'b1},  // R7 enable, no reload
    '{4'h5, 7'd1, 16'h0000, 3'd1, 16'h1111, 1'b1},  // R9 reserved
    '{4'hC, 7'd0, 16'h0000, 3'd1, 16'h1111, 1'b0},  // R7 disable, no reload
    '{4'hF, 7'd7, 16'h0000, 3'd7, 16'h7777, 1'b0},  // R9 reserved
    '{4'h1, 7'd11, 16'h1234, 3'd3, 16'h1234, 1'b0}, // R2 addr bits [2:0]=3
    '{4'h9, 7'd3, 16'hFFFF, 3'd3, 16'h1234, 1'b0}   // R9 reserved
  };

  function automatic logic [15:0] coef(input int k);
    return coefFlat[(k-1)*16 +: 16];
  endfunction

  task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cmd(input logic [3:0] c, input logic [6:0] a, input logic [15:0] d);
    @(negedge clk);
    cmdValid = 1'b1; cmdCode = c; cmdAddr = a; cmdData = d;
  endtask

  task automatic idle();
    @(negedge clk);
    cmdValid = 1'b0; cmdCode = 4'h0; cmdAddr = '0; cmdData = '0;
  endtask

  task automatic burst(input logic [3:0] c, input logic [6:0] a, input int n);
    for (int i = 0; i < n; i++) cmd(c, a, 16'h0);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    logic [127:0] snap;
    rstN = 1'b0; cmdValid = 1'b0; cmdCode = '0; cmdAddr = '0; cmdData = '0;
    repeat (3) @(negedge clk);
    check(coefFlat == '0 && !outEnable && !busy && !convStart, "R1 during reset",
          {coefFlat, outEnable, busy, convStart}, '0);
    rstN = 1'b1;
    @(negedge clk);
    check(coefFlat == '0 && !outEnable && !busy && !convStart, "R1 after reset",
          {coefFlat, outEnable, busy, convStart}, '0);

    // table walk: coefficient writes, start codes, reserved codes
    foreach (TBL[i]) begin
      cmd(TBL[i].code, TBL[i].addr, TBL[i].data);
      idle();
      check(coef(int'(TBL[i].idx)) == TBL[i].expV && outEnable == TBL[i].expOe,
            $sformatf("R2/R7/R9 table row %0d", i),
            {coef(int'(TBL[i].idx)), 3'b0, outEnable}, {TBL[i].expV, 3'b0, TBL[i].expOe});
    end

    // R5 erase, R6 busy one short of commit
    burst(4'h4, 7'd9, REP - 1);
    idle();
    check(busy == 1'b1, "R6 busy before erase commit", 128'(busy), 128'd1);
    cmd(4'h4, 7'd77, 16'h0);
    idle();
    check(nvmBits == '0, "R5 erase clears array", nvmBits, '0);
    check(busy == 1'b0, "R6 busy low after erase commit", 128'(busy), 128'd0);

    // R4 broken by a different code
    burst(4'h2, 7'd20, REP - 1);
    cmd(4'h0, 7'd20, 16'h0);
    idle();
    check(nvmBits == '0 && !busy, "R4 NOP break, no commit", {nvmBits[126:0], busy}, '0);

    // R4 broken by a different address
    burst(4'h2, 7'd5, 200);
    burst(4'h2, 7'd6, REP);
    idle();
    check(nvmBits == (128'd1 << 6), "R4 address change restarts run", nvmBits, 128'd1 << 6);

    // R11 idle gap, R9 reserved code inside a run, R3 commit
    burst(4'h2, 7'd20, REP - 1);
    idle();
    cmd(4'h3, 7'd20, 16'h0);
    idle();
    check(busy == 1'b1 && nvmBits == (128'd1 << 6), "R11 R9 run still pending",
          {nvmBits[126:0], busy}, {127'(128'd1 << 6), 1'b1});
    cmd(4'h2, 7'd20, 16'h0);
    idle();
    check(nvmBits == ((128'd1 << 6) | (128'd1 << 20)), "R3 bit 20 set",
          nvmBits, (128'd1 << 6) | (128'd1 << 20));
    burst(4'h2, 7'd127, REP);
    idle();
    snap = (128'd1 << 6) | (128'd1 << 20) | (128'd1 << 127);
    check(nvmBits == snap, "R3 bit 127 set, others kept", nvmBits, snap);

    // R8 reload with output disable (Eh)
    cmd(4'h1, 7'd2, 16'hABCD);
    cmd(4'hE, 7'd0, 16'h0);
    idle();
    check(convStart == 1'b1, "R7 convStart pulse", 128'(convStart), 128'd1);
    check(coef(1) == 16'h0010 && coef(7) == 16'h8000 && coef(2) == 16'h0000 &&
          coef(3) == 16'h0000 && !outEnable, "R8 reload from array",
          {coef(1), coef(2), coef(3), coef(7), outEnable}, {16'h0010, 32'h0, 16'h0, 16'h8000, 1'b0});
    idle();
    check(convStart == 1'b0, "R7 convStart one cycle", 128'(convStart), 128'd0);

    // R8 no reload on 8h
    cmd(4'h1, 7'd4, 16'h4444);
    cmd(4'h8, 7'd0, 16'h0);
    idle();
    check(coef(4) == 16'h4444 && outEnable, "R8 8h keeps registers",
          {coef(4), outEnable}, {16'h4444, 1'b1});

    // R10 array survives reset
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(nvmBits == snap, "R10 array kept over reset", nvmBits, snap);
    check(coefFlat == '0 && !outEnable, "R1 registers cleared by reset",
          {coefFlat, outEnable}, '0);

    // R3 reprogramming a set bit keeps the array
    burst(4'h2, 7'd20, REP);
    idle();
    check(nvmBits == snap, "R3 reprogram set bit", nvmBits, snap);

    // R5 erase clears programmed bits, R8 reload of an erased array
    burst(4'h4, 7'd0, REP);
    cmd(4'hA, 7'd0, 16'h0);
    idle();
    check(nvmBits == '0 && coefFlat == '0, "R5 R8 erase then reload",
          {nvmBits[15:0], coefFlat}, '0);
    finish();
  end
endmodule